// File: doc/BRIEF.md
# Commit-Point Program Counter and Branch Resolver

This block sits at the tail of an operand pipeline, at the point where instructions become architecturally committed. It owns the program counter and a committed copy of the stack-front pointer. For each instruction that commits, it moves the counter forward by that instruction's length through one dedicated adder. The same adder also executes control transfers. A relative transfer adds the operand to the counter. An absolute transfer feeds the operand through with the counter input held at zero.

When a transfer commits, the block checks the out-of-sequence tag of the instruction behind it. That tag says whether the fetch side already supplied the jump-target stream. If the tag does not match the actual outcome, the block raises a one-cycle flush, and every younger instruction must be turned into a dummy. Each instruction carries the stack-front value it would leave behind. At commit the block copies that value into a committed register, so a flush can restore the live stack pointer from a known-good value.

Top module: `ctrl_point`

## Requirements
- R1: While `rst_ni` is low and after its release, `pc_o` equals parameter `RESET_PC`, `sp_restore_o` equals `RESET_SP` and `flush_o` is 0.
- R2: A committing beat whose `xfer_i` is 2'b00 or 2'b11 (no transfer) sets `pc_o` on the next cycle to the old `pc_o` plus `len_i`, modulo 2^ADDR_W.
- R3: A committing beat with `xfer_i` = 2'b01 (relative) that is taken sets `pc_o` to old `pc_o` plus `operand_i`, modulo 2^ADDR_W. A transfer is taken when `cond_i` = 0, or when `cond_i` = 1 and `cond_met_i` = 1.
- R4: A committing beat with `xfer_i` = 2'b10 (absolute) that is taken sets `pc_o` to `operand_i`.
- R5: A conditional transfer whose condition is not met advances `pc_o` by `len_i`, as in R2.
- R6: One cycle after a committing transfer beat, `flush_o` is 1 exactly when taken differs from `next_oos_i`. So it is 1 for taken with the tag clear and for untaken with the tag set, and 0 for the other two cases and for every non-transfer beat.
- R7: `flush_o` lasts one cycle. A beat that arrives in a cycle where `flush_o` is 1 is discarded: `pc_o` and `sp_restore_o` stay unchanged and no new flush follows.
- R8: Each committing beat copies `sp_i` into `sp_restore_o` on the next cycle. When `flush_o` is high, `sp_restore_o` therefore holds the value committed by the transfer that caused the flush.
- R9: A committing beat with `phase1_i` = 1 (first phase of a two-phase stack order) leaves `pc_o` unchanged and never flushes, but still commits `sp_i` per R8.
- R10: A cycle with `valid_i` = 0, or with `dummy_i` = 1, leaves `pc_o` and `sp_restore_o` unchanged and produces no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction occupies the commit point this cycle |
| dummy_i | input | 1 | The instruction is a gap and does nothing |
| phase1_i | input | 1 | First phase of a two-phase stack order |
| xfer_i | input | 2 | 00 none, 01 relative, 10 absolute, 11 none |
| cond_i | input | 1 | The transfer is conditional |
| cond_met_i | input | 1 | Condition result for a conditional transfer |
| next_oos_i | input | 1 | Out-of-sequence tag of the following instruction |
| len_i | input | LEN_W | Instruction length |
| operand_i | input | ADDR_W | Transfer operand (offset or target) |
| sp_i | input | SP_W | Stack-front value carried by the instruction |
| pc_o | output | ADDR_W | Program counter |
| flush_o | output | 1 | One-cycle request to discard younger instructions |
| sp_restore_o | output | SP_W | Committed stack-front value used to restore on flush |

## Verification
Random beats mix every transfer kind with both condition values and both tag values, so all four cells of the decision table appear many times. Comparing relative against absolute shows whether the counter input is really forced to zero. Comparing met against unmet conditionals separates the operand path from the length path. Directed cases cover a beat landing during a flush (it must be discarded), a sequential step that wraps the counter past its top, and a first-phase stack order. Together these show that the counter hold and the stack commit are gated separately.

// File: rtl/ctrl_point_pkg.sv
package ctrl_point_pkg;
  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_REL  = 2'b01,
    XFER_ABS  = 2'b10,
    XFER_RSVD = 2'b11
  } xfer_e;
endpackage

// File: rtl/ctrl_resolve.sv
module ctrl_resolve
  import ctrl_point_pkg::*;
(
  input  logic       commit_i,
  input  logic       phase1_i,
  input  logic [1:0] xfer_i,
  input  logic       cond_i,
  input  logic       cond_met_i,
  input  logic       next_oos_i,
  output logic       advance_o,
  output logic       taken_o,
  output logic       abs_o,
  output logic       flush_req_o
);
  xfer_e xfer;
  logic  is_xfer;

  always_comb begin
    xfer        = xfer_e'(xfer_i);
    is_xfer     = !phase1_i && (xfer == XFER_REL || xfer == XFER_ABS);
    taken_o     = is_xfer && (!cond_i || cond_met_i);
    abs_o       = taken_o && (xfer == XFER_ABS);
    advance_o   = commit_i && !phase1_i;
    // mismatch between outcome and fetch-side tag means wrong stream behind
    flush_req_o = commit_i && is_xfer && (taken_o != next_oos_i);
  end
endmodule

// File: rtl/ctrl_adder.sv
module ctrl_adder #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] operand_i,
  input  logic              taken_i,
  input  logic              abs_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] a_in, b_in;

  always_comb begin
    a_in  = abs_i ? '0 : pc_i;
    b_in  = taken_i ? operand_i : {{PAD_W{1'b0}}, len_i};
    sum_o = a_in + b_in;
  end
endmodule

// File: rtl/ctrl_sp_shadow.sv
module ctrl_sp_shadow #(
  parameter int              SP_W     = 16,
  parameter logic [SP_W-1:0] RESET_SP = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SP_W-1:0] sp_i,
  output logic [SP_W-1:0] sp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_o <= RESET_SP;
    else if (load_i) sp_o <= sp_i;
  end
endmodule

// File: rtl/ctrl_point.sv
module ctrl_point #(
  parameter int                ADDR_W   = 32,
  parameter int                LEN_W    = 3,
  parameter int                SP_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  parameter logic [SP_W-1:0]   RESET_SP = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              dummy_i,
  input  logic              phase1_i,
  input  logic [1:0]        xfer_i,
  input  logic              cond_i,
  input  logic              cond_met_i,
  input  logic              next_oos_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] operand_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              flush_o,
  output logic [SP_W-1:0]   sp_restore_o
);
  logic              commit, advance, taken, abs_sel, flush_req;
  logic [ADDR_W-1:0] pc_q, pc_sum;
  logic              flush_q;

  // beat behind a flush belongs to the discarded stream
  assign commit = valid_i && !dummy_i && !flush_q;

  ctrl_resolve u_resolve (
    .commit_i    (commit),
    .phase1_i    (phase1_i),
    .xfer_i      (xfer_i),
    .cond_i      (cond_i),
    .cond_met_i  (cond_met_i),
    .next_oos_i  (next_oos_i),
    .advance_o   (advance),
    .taken_o     (taken),
    .abs_o       (abs_sel),
    .flush_req_o (flush_req)
  );

  ctrl_adder #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_adder (
    .pc_i      (pc_q),
    .len_i     (len_i),
    .operand_i (operand_i),
    .taken_i   (taken),
    .abs_i     (abs_sel),
    .sum_o     (pc_sum)
  );

  ctrl_sp_shadow #(.SP_W(SP_W), .RESET_SP(RESET_SP)) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (commit),
    .sp_i   (sp_i),
    .sp_o   (sp_restore_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_PC;
      flush_q <= 1'b0;
    end else begin
      if (advance) pc_q <= pc_sum;
      flush_q <= flush_req;
    end
  end

  assign pc_o    = pc_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/ctrl_point_chk.sv
module ctrl_point_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 3,
  parameter int SP_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              dummy_i,
  input logic              phase1_i,
  input logic [1:0]        xfer_i,
  input logic              cond_i,
  input logic              cond_met_i,
  input logic              next_oos_i,
  input logic [LEN_W-1:0]  len_i,
  input logic [ADDR_W-1:0] operand_i,
  input logic [SP_W-1:0]   sp_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              flush_o,
  input logic [SP_W-1:0]   sp_restore_o
);
  AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R7

  AST_FLUSH_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> ($stable(pc_o) && $stable(sp_restore_o))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || dummy_i) |=> ($stable(pc_o) && $stable(sp_restore_o) && !flush_o)); // R10

  AST_PHASE1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && phase1_i) |=> ($stable(pc_o) && !flush_o)); // R9

  AST_ABS_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dummy_i && !flush_o && !phase1_i && xfer_i == 2'b10 && (!cond_i || cond_met_i))
    |=> (pc_o == $past(operand_i))); // R4

  AST_SP_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dummy_i && !flush_o) |=> (sp_restore_o == $past(sp_i))); // R8

  AST_NO_XFER_NO_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (xfer_i == 2'b00 || xfer_i == 2'b11)) |=> !flush_o); // R6
endmodule

bind ctrl_point ctrl_point_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SP_W(SP_W)) u_chk (.*);

// File: tb/sim_ctrl_point.sv
module sim_ctrl_point;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 3;
  localparam int SP_W   = 16;
  localparam logic [ADDR_W-1:0] RST_PC = 32'h0000_0100;
  localparam logic [SP_W-1:0]   RST_SP = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 0, dummy = 0, phase1 = 0, cond = 0, cond_met = 0, oos = 0;
  logic [1:0] xfer = 0;
  logic [LEN_W-1:0] len = 0;
  logic [ADDR_W-1:0] operand = 0;
  logic [SP_W-1:0] sp = 0;
  logic [ADDR_W-1:0] pc_o;
  logic flush_o;
  logic [SP_W-1:0] sp_rest;

  always #5 clk = ~clk;

  ctrl_point #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SP_W(SP_W),
               .RESET_PC(RST_PC), .RESET_SP(RST_SP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .dummy_i(dummy),
    .phase1_i(phase1), .xfer_i(xfer), .cond_i(cond), .cond_met_i(cond_met),
    .next_oos_i(oos), .len_i(len), .operand_i(operand), .sp_i(sp),
    .pc_o(pc_o), .flush_o(flush_o), .sp_restore_o(sp_rest));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [ADDR_W-1:0] m_pc = RST_PC;
  logic [SP_W-1:0]   m_sp = RST_SP;
  logic              m_flush = 0;
  string ptag = "R1", ftag = "R1", stag = "R1";

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit is_taken(logic [1:0] x, logic c, logic cm);
    return (x == 2'b01 || x == 2'b10) && (!c || cm);
  endfunction

  task automatic step(logic v, logic d, logic p, logic [1:0] x, logic c, logic cm,
                      logic o, logic [LEN_W-1:0] l, logic [ADDR_W-1:0] op, logic [SP_W-1:0] s);
    bit isx, tk;
    @(negedge clk);
    check(ptag, "pc_o", 64'(pc_o), 64'(m_pc));
    check(ftag, "flush_o", 64'(flush_o), 64'(m_flush));
    check(stag, "sp_restore_o", 64'(sp_rest), 64'(m_sp));
    valid = v; dummy = d; phase1 = p; xfer = x; cond = c; cond_met = cm;
    oos = o; len = l; operand = op; sp = s;
    if (!(v && !d && !m_flush)) begin
      ptag = (v && !d) ? "R7" : "R10";
      ftag = ptag; stag = ptag;
      m_flush = 0;
    end else begin
      m_sp = s; stag = "R8";
      if (p) begin
        ptag = "R9"; ftag = "R9"; m_flush = 0;
      end else begin
        isx = (x == 2'b01 || x == 2'b10);
        tk  = is_taken(x, c, cm);
        if (tk) begin
          m_pc = (x == 2'b10) ? op : m_pc + op;
          ptag = (x == 2'b10) ? "R4" : "R3";
        end else begin
          m_pc = m_pc + ADDR_W'(l);
          ptag = isx ? "R5" : "R2";
        end
        m_flush = isx && (tk != o);
        ftag = "R6";
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check("R1", "pc_o in reset", 64'(pc_o), 64'(RST_PC));
    check("R1", "sp_restore_o in reset", 64'(sp_rest), 64'(RST_SP));
    check("R1", "flush_o in reset", 64'(flush_o), 64'(0));
    rst_n = 1'b1;
    // directed: sequential, relative, absolute
    step(1,0,0,2'b00,0,0,0,3'd4,32'h0,16'h0041);
    step(1,0,0,2'b01,0,0,1,3'd2,32'h20,16'h0042);          // R3 taken, tagged -> no flush
    step(1,0,0,2'b10,1,1,1,3'd2,32'h8000,16'h0043);        // R4 taken cond, tagged
    // four decision cells (R6)
    step(1,0,0,2'b01,1,1,0,3'd2,32'h10,16'h0050);          // taken, untagged -> flush
    step(1,0,0,2'b00,0,0,0,3'd7,32'h0,16'h0051);           // discarded behind flush (R7)
    step(1,0,0,2'b01,1,0,0,3'd3,32'h10,16'h0052);          // untaken, untagged (R5)
    step(1,0,0,2'b10,1,0,1,3'd1,32'h10,16'h0053);          // untaken, tagged -> flush
    step(0,0,0,2'b00,0,0,0,3'd0,32'h0,16'h0000);
    // phase1 and dummy
    step(1,0,1,2'b01,0,0,0,3'd2,32'h44,16'h0060);          // R9
    step(1,1,0,2'b10,0,0,0,3'd2,32'h44,16'h0061);          // R10
    // wrap (R2)
    step(1,0,0,2'b10,0,0,1,3'd2,32'hFFFF_FFFE,16'h0070);
    step(1,0,0,2'b11,0,0,0,3'd5,32'h0,16'h0071);
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) != 0, ($urandom % 10) == 0, ($urandom % 10) == 0,
           2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           LEN_W'($urandom), ADDR_W'($urandom), SP_W'($urandom));
    end
    step(0,0,0,2'b00,0,0,0,3'd0,32'h0,16'h0);
    step(0,0,0,2'b00,0,0,0,3'd0,32'h0,16'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule